// File: doc/BRIEF.md
# SAR ADC Conversion and Readout Sequencer

This block drives the convert line, chip-select, serial clock and controller data-out line of a serial successive-approximation converter. Each accepted start request produces exactly one fresh sample word. The word comes back on a one-cycle valid strobe together with its data. The conversion wait, serial clock divider, word width and minimum chip-select idle time are all parameters.

A static mode input selects one of two wiring schemes. In the first, a dedicated convert output rises to start the conversion and stays high until readout ends. In the second, chip-select also serves as the convert line. The converter starts on the rising edge of chip-select, so the block first issues an empty chip-select pulse. It then waits out the conversion with chip-select high and issues a second pulse to read the result. A single pulse would return the word from an earlier conversion, and the block never does that.

Top module: `adc_sar_seq`

## Requirements
- R1: While reset is high and on the first cycle after it falls, chip-select is high, convert is low, the serial clock is low, data-out is low, and busy and valid are low.
- R2: With the mode input low, convert rises on the edge after an accepted start. Chip-select stays high for CONV_CYCLES cycles after that rise, then goes low for one pulse of WIDTH serial clocks. Convert falls on the same edge at which chip-select returns high. Each sample has exactly one chip-select pulse.
- R3: With the mode input high, each sample has exactly two chip-select low pulses. The first lasts DIV cycles and has no serial clock edges. The second begins at least max(CONV_CYCLES, QUIET_CYCLES) cycles after the first ends.
- R4: The returned word is the converter result of the conversion started by the same request, never that of an earlier conversion. Readout begins no sooner than CONV_CYCLES cycles after the conversion edge.
- R5: The word is WIDTH bits, assembled MSB first from the data-in line sampled on each rising serial clock edge. The serial clock idles low, has a period of DIV system cycles and makes exactly WIDTH rising edges per sample.
- R6: Data-out is high on every cycle that busy is high, which covers the whole conversion and the whole readout word. It is low while idle.
- R7: Valid is high for exactly one cycle per sample. Busy rises on the edge after the start is accepted and falls on the same edge at which valid rises.
- R8: A start request while busy is ignored: it yields no extra word, and the word in progress still holds the result of its own conversion.
- R9: Between any two consecutive chip-select low pulses, including pulses of different samples, chip-select stays high for at least QUIET_CYCLES cycles.
- R10: The serial clock is high only while chip-select is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_cs_conv | input | 1 | Static wiring select: 0 means separate convert line, 1 means chip-select acts as convert |
| start | input | 1 | Request for one sample; ignored while busy |
| busy | output | 1 | High from the accepted start until the valid strobe |
| sample_valid | output | 1 | One-cycle strobe marking a new word |
| sample_data | output | WIDTH | Assembled sample word |
| adc_cnv | output | 1 | Convert line, used when mode_cs_conv is 0 |
| adc_cs_n | output | 1 | Active-low chip-select |
| adc_sclk | output | 1 | Serial clock, idles low |
| spi_mosi | output | 1 | Controller data-out into the converter serial input, held high during a sample |
| spi_miso | input | 1 | Converter serial data into the controller |

## Verification
The bench builds the block with WIDTH 18, DIV 3, CONV_CYCLES 5 and QUIET_CYCLES 8. An 18-bit word does not fill whole bytes, so any break in the data-out level at a byte boundary would show. An odd divider makes the serial clock low and high phases unequal, which tests the sampling edge and the bit count. Because QUIET_CYCLES is larger than CONV_CYCLES, the gap between the two pulses in chip-select/convert mode is set by the quiet time and not by the conversion time. A converter model latches a new input value at each conversion edge, so a stale readout returns a different word.

// File: rtl/adc_sar_seq_pkg.sv
package adc_sar_seq_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TRIG,
    ST_CONV,
    ST_READ,
    ST_QUIET
  } seq_state_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sar_timer.sv
module adc_sar_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         expired
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);
endmodule

// File: rtl/adc_sar_sclk.sv
module adc_sar_sclk #(
  parameter int DIV = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic sclk,
  output logic rise_tick,
  output logic fall_tick
);
  localparam int HALF = DIV / 2;
  localparam int DW   = (DIV > 2) ? $clog2(DIV) : 1;

  logic [DW-1:0] cnt;

  assign rise_tick = run && (cnt == DW'(HALF - 1));
  assign fall_tick = run && (cnt == DW'(DIV - 1));

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt  <= '0;
      sclk <= 1'b0;
    end else begin
      cnt <= fall_tick ? '0 : cnt + 1'b1;
      if (rise_tick)      sclk <= 1'b1;
      else if (fall_tick) sclk <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_sar_shift.sv
module adc_sar_shift #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             din,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= {q[WIDTH-2:0], din};
  end
endmodule

// File: rtl/adc_sar_seq.sv
module adc_sar_seq
  import adc_sar_seq_pkg::*;
#(
  parameter int WIDTH        = 16,
  parameter int DIV          = 4,
  parameter int CONV_CYCLES  = 40,
  parameter int QUIET_CYCLES = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_cs_conv,
  input  logic             start,
  output logic             busy,
  output logic             sample_valid,
  output logic [WIDTH-1:0] sample_data,
  output logic             adc_cnv,
  output logic             adc_cs_n,
  output logic             adc_sclk,
  output logic             spi_mosi,
  input  logic             spi_miso
);
  localparam int GAP     = imax(CONV_CYCLES, QUIET_CYCLES);
  localparam int CNT_MAX = imax(DIV, imax(GAP, QUIET_CYCLES));
  localparam int CW      = $clog2(CNT_MAX + 1);
  localparam int BW      = $clog2(WIDTH + 1);

  seq_state_t        state;
  logic [BW-1:0]     bit_cnt;
  logic              t_load, t_expired;
  logic [CW-1:0]     t_val;
  logic              rise_tick, fall_tick;
  logic [WIDTH-1:0]  shift_q;
  logic              last_fall;

  assign last_fall = (state == ST_READ) && fall_tick && (bit_cnt == '0);

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    case (state)
      ST_IDLE: if (start) begin
        t_load = 1'b1;
        t_val  = mode_cs_conv ? CW'(DIV - 1) : CW'(CONV_CYCLES - 1);
      end
      ST_TRIG: if (t_expired) begin
        t_load = 1'b1;
        t_val  = CW'(GAP - 1);
      end
      ST_READ: if (last_fall) begin
        t_load = 1'b1;
        t_val  = CW'(QUIET_CYCLES - 1);
      end
      default: ;
    endcase
  end

  adc_sar_timer #(.W(CW)) u_timer (
    .clk(clk), .rst(rst), .load(t_load), .load_val(t_val), .expired(t_expired)
  );

  adc_sar_sclk #(.DIV(DIV)) u_sclk (
    .clk(clk), .rst(rst), .run(state == ST_READ),
    .sclk(adc_sclk), .rise_tick(rise_tick), .fall_tick(fall_tick)
  );

  adc_sar_shift #(.WIDTH(WIDTH)) u_shift (
    .clk(clk), .rst(rst), .en(rise_tick), .din(spi_miso), .q(shift_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      busy         <= 1'b0;
      sample_valid <= 1'b0;
      sample_data  <= '0;
      adc_cnv      <= 1'b0;
      adc_cs_n     <= 1'b1;
      spi_mosi     <= 1'b0;
      bit_cnt      <= '0;
    end else begin
      sample_valid <= 1'b0;
      case (state)
        ST_IDLE: if (start) begin
          busy     <= 1'b1;
          spi_mosi <= 1'b1;
          if (mode_cs_conv) begin
            adc_cs_n <= 1'b0;
            state    <= ST_TRIG;
          end else begin
            adc_cnv  <= 1'b1;
            state    <= ST_CONV;
          end
        end
        ST_TRIG: if (t_expired) begin
          adc_cs_n <= 1'b1;
          state    <= ST_CONV;
        end
        ST_CONV: if (t_expired) begin
          adc_cs_n <= 1'b0;
          bit_cnt  <= BW'(WIDTH - 1);
          state    <= ST_READ;
        end
        ST_READ: if (fall_tick) begin
          if (bit_cnt == '0) begin
            adc_cs_n <= 1'b1;
            adc_cnv  <= 1'b0;
            state    <= ST_QUIET;
          end else begin
            bit_cnt <= bit_cnt - 1'b1;
          end
        end
        ST_QUIET: if (t_expired) begin
          sample_valid <= 1'b1;
          sample_data  <= shift_q;
          busy         <= 1'b0;
          spi_mosi     <= 1'b0;
          state        <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/adc_sar_seq_chk.sv
module adc_sar_seq_chk (
  input logic clk,
  input logic rst,
  input logic mode_cs_conv,
  input logic busy,
  input logic sample_valid,
  input logic adc_cnv,
  input logic adc_cs_n,
  input logic adc_sclk,
  input logic spi_mosi
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (adc_cs_n && !adc_cnv && !adc_sclk && !busy && !sample_valid && !spi_mosi));

  // R10
  sclk_under_cs_chk: assert property (@(posedge clk) disable iff (rst)
    adc_sclk |-> !adc_cs_n);

  // R6
  mosi_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (adc_cnv || !adc_cs_n) |-> spi_mosi);

  // R7
  valid_single_chk: assert property (@(posedge clk) disable iff (rst)
    sample_valid |=> !sample_valid);

  // R7
  busy_end_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> sample_valid);

  // R2
  sep_read_in_conv_chk: assert property (@(posedge clk) disable iff (rst)
    (!mode_cs_conv && $rose(adc_sclk)) |-> adc_cnv);

  // R3
  comb_no_cnv_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_cs_conv && !busy) |-> !adc_cnv);
endmodule

bind adc_sar_seq adc_sar_seq_chk u_chk (
  .clk(clk), .rst(rst), .mode_cs_conv(mode_cs_conv), .busy(busy),
  .sample_valid(sample_valid), .adc_cnv(adc_cnv), .adc_cs_n(adc_cs_n),
  .adc_sclk(adc_sclk), .spi_mosi(spi_mosi)
);

// File: tb/adc_sar_seq_tb.sv
`timescale 1ns/1ps
module adc_sar_seq_tb;
  localparam int W     = 18;
  localparam int DIV   = 3;
  localparam int CONV  = 5;
  localparam int QUIET = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mode = 1'b0;
  logic start = 1'b0;
  logic busy, valid, cnv, cs_n, sclk, mosi;
  logic miso = 1'b0;
  logic [W-1:0] data;

  always #5 clk = ~clk;

  adc_sar_seq #(.WIDTH(W), .DIV(DIV), .CONV_CYCLES(CONV), .QUIET_CYCLES(QUIET)) u_dut (
    .clk(clk), .rst(rst), .mode_cs_conv(mode), .start(start), .busy(busy),
    .sample_valid(valid), .sample_data(data), .adc_cnv(cnv), .adc_cs_n(cs_n),
    .adc_sclk(sclk), .spi_mosi(mosi), .spi_miso(miso)
  );

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [W-1:0] exp_q[$];
  logic [W-1:0] analog_val = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // converter model and monitor
  logic [W-1:0] conv_res = '0, out_reg = '0;
  int cyc = 0, trig_cyc = 0, bit_idx = 0;
  int high_len = 0, low_len = 0, pulses = 0, pulse_rises = 0, rises = 0, mosi_bad = 0;
  bit conv_pend = 1'b0, seen_pulse = 1'b0;
  logic p_cs = 1'b1, p_cnv = 1'b0, p_sclk = 1'b0, p_busy = 1'b0, p_valid = 1'b0;

  always @(negedge clk) begin
    if (!rst) begin
      cyc++;
      if ((!mode && cnv && !p_cnv) || (mode && cs_n && !p_cs)) begin
        conv_res  = analog_val;
        trig_cyc  = cyc;
        conv_pend = 1'b1;
      end
      if (p_cs && !cs_n) begin
        if (seen_pulse) chk(high_len >= QUIET, "R9 cs high gap", high_len, QUIET);
        seen_pulse = 1'b1;
        if (conv_pend) begin
          chk(cyc - trig_cyc >= CONV, "R4 conversion wait", cyc - trig_cyc, CONV);
          conv_pend = 1'b0;
        end
        out_reg = conv_res;
        bit_idx = W - 1;
        miso = out_reg[W-1];
        pulses++;
        pulse_rises = 0;
        high_len = 0;
        low_len = 0;
      end
      if (!p_cs && cs_n) begin
        if (mode && pulses == 1) begin
          chk(pulse_rises == 0, "R3 trigger pulse clocks", pulse_rises, 0);
          chk(low_len == DIV, "R3 trigger pulse length", low_len, DIV);
        end
        if (!mode) chk(p_cnv && !cnv, "R2 cnv falls with cs", {p_cnv, cnv}, 2'b10);
      end
      if (sclk && !p_sclk) begin
        rises++;
        pulse_rises++;
        chk(!cs_n, "R10 sclk while cs low", cs_n, 0);
      end
      if (!sclk && p_sclk && bit_idx > 0) begin
        bit_idx--;
        miso = out_reg[bit_idx];
      end
      if (busy != mosi) mosi_bad++;
      if (cs_n) high_len++; else low_len++;
      if (valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R8 unexpected word", data, 0);
        end else begin
          logic [W-1:0] e;
          e = exp_q.pop_front();
          chk(data == e, "R4 R5 sample word", data, e);
        end
        chk(pulses == (mode ? 2 : 1), mode ? "R3 pulse count" : "R2 pulse count", pulses, mode ? 2 : 1);
        chk(rises == W, "R5 sclk rise count", rises, W);
        chk(mosi_bad == 0, "R6 mosi level", mosi_bad, 0);
        chk(p_busy && !busy, "R7 busy ends with valid", {p_busy, busy}, 2'b10);
        pulses = 0; rises = 0; mosi_bad = 0;
      end
      if (p_valid && valid) chk(1'b0, "R7 valid width", 2, 1);
      p_cs = cs_n; p_cnv = cnv; p_sclk = sclk; p_busy = busy; p_valid = valid;
    end
  end

  task automatic run_sample(input logic m, input logic [W-1:0] v, input bit poke);
    @(negedge clk);
    mode = m;
    analog_val = v;
    exp_q.push_back(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R7 busy after start", busy, 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      analog_val = ~v;
      start = 1'b1;   // R8: ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1
    chk(cs_n && !cnv && !sclk && !busy && !valid && !mosi, "R1 reset state",
        {cs_n, cnv, sclk, busy, valid, mosi}, 6'b100000);
    run_sample(1'b0, 18'h2A5C3, 1'b0);
    run_sample(1'b0, 18'h3FFFF, 1'b1);
    run_sample(1'b1, 18'h00000, 1'b0);
    run_sample(1'b1, 18'h20001, 1'b1);
    run_sample(1'b1, 18'h15555, 1'b0);
    run_sample(1'b0, 18'h0F0F0, 1'b0);
    run_sample(1'b1, 18'h3A5A5, 1'b0);
    repeat (40) @(negedge clk);
    chk(!busy && exp_q.size() == 0, "R8 idle after ignored starts", busy, 0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule